// File: doc/BRIEF.md
# Receive Frame Holding Queue

This block sits between a serial receiver and a register read port. Each time the receiver finishes a frame it pulses a done strobe with the eight data bits, a ninth bit and a framing-error flag. The block keeps up to two finished frames in arrival order, so software can be late by one frame while a further frame is still being shifted in by the receiver. The ninth bit and the framing-error flag are stored with each byte and follow it to the head of the queue.

The oldest stored frame is always shown on the head outputs. A read strobe removes it. A ready flag reports that the queue is not empty, and an interrupt output passes that flag through an enable mask. If a frame finishes while both slots are occupied and nothing is removed in that cycle, the frame is dropped and a sticky overrun flag is raised. While that flag is set, no frame is stored. The only way to clear it is to drop the receive enable low for at least one cycle and then raise it again.

Top module: `rx_pair_buffer`

## Requirements
- R1: Up to DEPTH (default 2) frames are held in arrival order, and the head outputs show the oldest stored frame. The occupancy never exceeds DEPTH.
- R2: A done strobe with rx_en high and overrun clear, arriving when the queue is full and no pop is taken in the same cycle, sets overrun at the next edge. The frame is discarded and the stored frames are unchanged.
- R3: While overrun is set, done strobes store nothing.
- R4: overrun stays set while rx_en is high. It is cleared at the first edge where rx_en is low. While rx_en is low, done strobes are ignored.
- R5: head_bit9 and head_ferr are the ninth bit and framing flag stored with the head byte. They are kept per entry, not per block.
- R6: A pop makes the head data, ninth bit and framing flag those of the next stored frame.
- R7: ready rises in the cycle after a frame is stored. It falls only after a pop that leaves the queue empty.
- R8: irq is high exactly when ready and irq_en are both high.
- R9: A store and a pop in the same cycle are both taken and the occupancy stays the same. This includes the full case, where no overrun results.
- R10: A pop while the queue is empty is ignored. The head outputs, ready and overrun are unchanged.
- R11: After reset, ready, irq and overrun are low and the head outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low clears overrun and blocks stores |
| wr_stb | input | 1 | Frame-done strobe from the receiver |
| wr_data | input | DATA_W | Received byte |
| wr_bit9 | input | 1 | Received ninth bit |
| wr_ferr | input | 1 | Framing error of the received frame |
| rd_stb | input | 1 | Pop the head entry |
| irq_en | input | 1 | Interrupt enable mask |
| head_data | output | DATA_W | Byte of the head entry |
| head_bit9 | output | 1 | Ninth bit of the head entry |
| head_ferr | output | 1 | Framing flag of the head entry |
| ready | output | 1 | Queue holds at least one frame |
| irq | output | 1 | ready gated by irq_en |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its defaults, DATA_W = 8 and DEPTH = 2. With only two slots, every ordering of five cycle-operations can be swept from reset: idle, store, pop, store with pop, and an enable drop. This covers the full-with-pop, empty-pop, overrun-then-clear and refill paths. Each sweep alternates irq_en and uses a distinct data pattern, so the per-entry status bits can be told apart at the head.

// File: rtl/rx_pair_buffer.sv
module rx_pair_buffer #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              wr_ferr,
  input  logic              rd_stb,
  input  logic              irq_en,
  output logic [DATA_W-1:0] head_data,
  output logic              head_bit9,
  output logic              head_ferr,
  output logic              ready,
  output logic              irq,
  output logic              overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DATA_W + 2;

  logic [EW-1:0] slot [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          pop_ok, full, take, ovr_hit;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_ok  = rd_stb && (count != '0);
  assign full    = (count == CW'(DEPTH));
  assign take    = wr_stb && rx_en && !overrun && (!full || pop_ok);
  assign ovr_hit = wr_stb && rx_en && !overrun && full && !pop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (take) begin
        slot[wr_ptr] <= {wr_ferr, wr_bit9, wr_data};
        wr_ptr       <= step(wr_ptr);
      end
      if (pop_ok) rd_ptr <= step(rd_ptr);
      if (take && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !take) count <= count - 1'b1;
      if (!rx_en)       overrun <= 1'b0;
      else if (ovr_hit) overrun <= 1'b1;
    end
  end

  assign {head_ferr, head_bit9, head_data} = slot[rd_ptr];
  assign ready = (count != '0);
  assign irq   = ready & irq_en;
endmodule

// File: rtl/rx_pair_buffer_chk.sv
module rx_pair_buffer_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  parameter int CW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic [DATA_W-1:0] head_data,
  input logic              ready,
  input logic              overrun,
  input logic [CW-1:0]     count
);
  a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r2_overrun_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !overrun && wr_stb && count == CW'(DEPTH) && !rd_stb) |=> overrun);

  a_r3_no_store_in_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !rd_stb) |=> $stable(count));

  a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && rx_en) |=> overrun);

  a_r4_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !overrun);

  a_r7_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(wr_stb));

  a_r7_ready_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(rd_stb));

  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !ready && !wr_stb) |=> ($stable(head_data) && !ready));
endmodule

bind rx_pair_buffer rx_pair_buffer_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .head_data(head_data), .ready(ready), .overrun(overrun), .count(count)
);

// File: tb/rx_pair_buffer_tb.sv
`timescale 1ns/1ps
module rx_pair_buffer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, wr_stb = 1'b0, wr_bit9 = 1'b0, wr_ferr = 1'b0;
  logic       rd_stb = 1'b0, irq_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] head_data;
  logic       head_bit9, head_ferr, ready, irq, overrun;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [9:0] q [2];
  int         q_n;
  bit         m_ovr;

  always #4 clk = ~clk;

  rx_pair_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .wr_bit9(wr_bit9), .wr_ferr(wr_ferr), .rd_stb(rd_stb), .irq_en(irq_en),
    .head_data(head_data), .head_bit9(head_bit9), .head_ferr(head_ferr),
    .ready(ready), .irq(irq), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rx_en = 1'b1; wr_stb = 0; rd_stb = 0;
    @(negedge clk);
    rst_n = 1'b1;
    q_n = 0; m_ovr = 0;
  endtask

  task automatic compare();
    chk("R7 ready", ready, q_n != 0);
    chk("R8 irq", irq, (q_n != 0) && irq_en);
    chk("R4 overrun", overrun, m_ovr);
    if (q_n != 0) begin
      chk("R1 head data", head_data, q[0][7:0]);
      chk("R5 head bit9", head_bit9, q[0][8]);
      chk("R5 head ferr", head_ferr, q[0][9]);
    end
  endtask

  // op: 0 idle, 1 store, 2 pop, 3 store+pop, 4 enable low
  task automatic step_op(input int op, input logic [7:0] d);
    bit wr, rd, en, pop, take;
    logic [9:0] ent;
    logic [9:0] head_before;
    wr = (op == 1 || op == 3);
    rd = (op == 2 || op == 3);
    en = (op != 4);
    ent = {d[0] ^ d[3], d[5], d};
    head_before = {head_ferr, head_bit9, head_data};
    @(negedge clk);
    wr_stb = wr; rd_stb = rd; rx_en = en;
    wr_data = d; wr_bit9 = ent[8]; wr_ferr = ent[9];
    @(posedge clk);
    #2;
    wr_stb = 0; rd_stb = 0;
    pop  = rd && (q_n > 0);
    take = wr && en && !m_ovr && (q_n < 2 || pop);
    if (!en) m_ovr = 0;
    else if (wr && !m_ovr && q_n == 2 && !pop) m_ovr = 1;
    if (pop) begin q[0] = q[1]; q_n--; end
    if (take) begin q[q_n] = ent; q_n++; end
    if (rd && !pop && !take)
      chk("R10 empty pop head", {head_ferr, head_bit9, head_data}, head_before);
    compare();
  endtask

  initial begin
    #3;
    chk("R11 reset ready", ready, 0);
    chk("R11 reset irq", irq, 0);
    chk("R11 reset overrun", overrun, 0);
    chk("R11 reset head", {head_ferr, head_bit9, head_data}, 10'h0);
    for (int s = 0; s < 3125; s++) begin
      int code;
      code = s;
      do_reset();
      irq_en = s[0];
      for (int k = 0; k < 5; k++) begin
        step_op(code % 5, 8'((s * 7 + k * 37 + 3) & 8'hFF));
        code = code / 5;
      end
    end
    // directed R9 on a full queue, R2 then R3, R6 order
    do_reset();
    irq_en = 1;
    step_op(1, 8'h11); step_op(1, 8'h29);
    step_op(3, 8'h3A);
    chk("R9 full store+pop no overrun", overrun, 0);
    chk("R6 head after pop", head_data, 8'h29);
    step_op(1, 8'h44);
    chk("R2 overrun on full", overrun, 1);
    step_op(2, 8'h00);
    step_op(1, 8'h55);
    chk("R3 no store in overrun", head_data, 8'h3A);
    step_op(2, 8'h00);
    chk("R3 queue emptied", ready, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule